// File: doc/BRIEF.md
# Two-Channel Cycle-Stealing DMA Controller

This block moves data between memory locations on a bus that it shares with a processor. Two independent channels each hold a source pointer, a destination pointer, a forward pointer, and a transfer counter with a reload value. A channel gets work from one of two places: a software strobe written through the register port, or a rising edge on one selected interrupt line. Each piece of work moves a single byte or a single 16-bit word. The block raises a bus request. When the grant arrives it performs one read cycle into an internal latch and then one write cycle from that latch. After that it drops the request for at least one cycle, so that the processor gets the bus back.

Software programs a channel through a small register port. Address bit 3 selects the channel and bits 2:0 select the register inside it. The forward pointer supplies the address on the side that advances, which is either the source or the destination as the channel's direction bit chooses. The other side stays fixed at its programmed pointer. When the counter runs out, the channel either switches itself off or refills the counter and rewinds the forward pointer, and it pulses a completion flag. Interrupt lines reach the block only as plain inputs. Neither interrupt masking nor interrupt priority gates them, and the block alters no interrupt state.

Top module: `cs_dma2`

## Requirements
- R1: The two channels are programmed and counted independently. When both have a pending request at the moment the bus is granted, channel 0 is served first.
- R2: After reset the bus request, read strobe, write strobe and done flags are low, and every register reads back as zero.
- R3: One transfer is a read cycle (bus_rd) at the source-side address, followed in the very next cycle by a write cycle (bus_wr) at the destination-side address that carries the data read.
- R4: With control bit 1 at 0 (byte mode), bus_word is low during the transfer, only bits 7:0 of the read data are moved, and bus_wdata bits 15:8 are zero. With bit 1 at 1 (word mode), bus_word is high and all 16 bits are moved.
- R5: The forward pointer reads at sub-address 5. It is loaded when a write to the control register (sub-address 3) changes bit 0 from 0 to 1: from the source pointer when control bit 4 is 0, and from the destination pointer when bit 4 is 1. It advances by 1 in byte mode or by 2 in word mode after each transfer, and it replaces the address on the side that bit 4 selects.
- R6: A write to sub-address 2 loads both the counter and the reload value. Each transfer decrements the counter, which reads at sub-address 2. With control bit 2 at 0, the transfer that takes the counter from 1 to 0 clears control bit 0 and pulses that channel's done bit for exactly one cycle.
- R7: With control bit 2 at 1 (repeat), the final transfer refills the counter from the reload value (readable at sub-address 6), rewinds the forward pointer to its base, leaves control bit 0 set, and pulses done for one cycle.
- R8: Writing a 1 to bit 0 of sub-address 4 requests one transfer on an enabled channel. The same write to a disabled channel is ignored, and no bus request follows.
- R9: With control bit 3 at 1, a rising edge on interrupt line number control[7:5] requests a transfer. A line held high does not request again, and edges on lines that are not selected are ignored.
- R10: Each channel keeps one pending flag. Requests that arrive while it is set are merged, so they produce a single transfer.
- R11: bus_rd and bus_wr are only driven while bus_gnt is high. After each write cycle bus_req is low for at least one cycle.
- R12: bus_rd and bus_wr are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Bit 3 channel, bits 2:0 register |
| cfg_wdata | input | ADDR_W (20) | Register write data |
| cfg_rdata | output | ADDR_W (20) | Register read data (combinational) |
| irq | input | IRQ_N (8) | Interrupt request lines usable as triggers |
| bus_req | output | 1 | Bus request to the shared-bus arbiter |
| bus_gnt | input | 1 | Bus grant |
| bus_rd | output | 1 | Read cycle strobe |
| bus_wr | output | 1 | Write cycle strobe |
| bus_word | output | 1 | 1 = 16-bit access, 0 = byte access |
| bus_addr | output | ADDR_W (20) | Bus address |
| bus_wdata | output | DATA_W (16) | Write data from the latch |
| bus_rdata | input | DATA_W (16) | Read data, valid in the read cycle |
| done | output | 2 | One-cycle completion pulse per channel |

## Verification
Three patterns exercise the transfer path. The first is a word channel with the source advancing, started by software strobes. It separates forward-pointer stepping from the fixed destination and shows that the final transfer disables the channel. The second is a byte channel with the destination advancing, triggered by interrupt edges. It uses a held level, an unselected line and a repeat-mode wrap, so that edge detection can be told apart from level sensing and reload from stop. The third holds the grant low while several requests accumulate on both channels. The order in which transfers come out then separates fixed channel priority from arrival order, and the number of transfers separates merging from counting.

// File: rtl/cs_dma_pkg.sv
package cs_dma_pkg;

   typedef enum logic [1:0] {
      MV_IDLE  = 2'd0,
      MV_READ  = 2'd1,
      MV_WRITE = 2'd2,
      MV_REST  = 2'd3
   } mv_state_t;

   // register sub-addresses inside one channel
   localparam logic [2:0] RG_SRC    = 3'd0;
   localparam logic [2:0] RG_DST    = 3'd1;
   localparam logic [2:0] RG_COUNT  = 3'd2;
   localparam logic [2:0] RG_CTRL   = 3'd3;
   localparam logic [2:0] RG_STROBE = 3'd4;
   localparam logic [2:0] RG_FWD    = 3'd5;
   localparam logic [2:0] RG_RELOAD = 3'd6;

   // control register bit positions
   localparam int CB_EN   = 0;
   localparam int CB_WORD = 1;
   localparam int CB_RPT  = 2;
   localparam int CB_HW   = 3;
   localparam int CB_DIR  = 4;
   localparam int CB_SEL  = 5;

endpackage

// File: rtl/cs_dma_chan.sv
module cs_dma_chan
   import cs_dma_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int CNT_W  = 16,
   parameter int IRQ_N  = 8,
   localparam int SEL_W = $clog2(IRQ_N)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [2:0]        cfg_reg,
   input  logic [ADDR_W-1:0] cfg_wdata,
   input  logic [IRQ_N-1:0]  irq_rise,
   input  logic              take,
   input  logic              fin,
   output logic              pend,
   output logic [ADDR_W-1:0] rd_addr,
   output logic [ADDR_W-1:0] wr_addr,
   output logic              word,
   output logic [ADDR_W-1:0] rd_data,
   output logic              done
);

   logic [ADDR_W-1:0] src_q, dst_q, fwd_q, step;
   logic [CNT_W-1:0]  cnt_q, rld_q;
   logic              en_q, word_q, rpt_q, hw_q, dir_q, pend_q, done_q;
   logic [SEL_W-1:0]  sel_q;
   logic              wr_ctrl, sw_hit, hw_hit, last, en_nxt, new_req, pend_nxt;
   logic [ADDR_W-1:0] ctrl_v;

   always_comb begin
      wr_ctrl  = cfg_we && (cfg_reg == RG_CTRL);
      sw_hit   = cfg_we && (cfg_reg == RG_STROBE) && cfg_wdata[0];
      hw_hit   = hw_q && irq_rise[sel_q];
      last     = fin && (cnt_q == CNT_W'(1));
      step     = word_q ? ADDR_W'(2) : ADDR_W'(1);
      if (wr_ctrl)
         en_nxt = cfg_wdata[CB_EN];
      else if (last && !rpt_q)
         en_nxt = 1'b0;
      else
         en_nxt = en_q;
      new_req  = en_q && (sw_hit || hw_hit);
      pend_nxt = ((pend_q && !take) || new_req) && en_nxt;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         src_q  <= '0;
         dst_q  <= '0;
         fwd_q  <= '0;
         cnt_q  <= '0;
         rld_q  <= '0;
         en_q   <= 1'b0;
         word_q <= 1'b0;
         rpt_q  <= 1'b0;
         hw_q   <= 1'b0;
         dir_q  <= 1'b0;
         sel_q  <= '0;
         pend_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         if (fin) begin
            if (last && rpt_q) begin
               cnt_q <= rld_q;
               fwd_q <= dir_q ? dst_q : src_q;
            end else begin
               cnt_q <= cnt_q - CNT_W'(1);
               fwd_q <= fwd_q + step;
            end
         end
         if (cfg_we) begin
            case (cfg_reg)
               RG_SRC:   src_q <= cfg_wdata;
               RG_DST:   dst_q <= cfg_wdata;
               RG_COUNT: begin
                  cnt_q <= cfg_wdata[CNT_W-1:0];
                  rld_q <= cfg_wdata[CNT_W-1:0];
               end
               RG_CTRL: begin
                  word_q <= cfg_wdata[CB_WORD];
                  rpt_q  <= cfg_wdata[CB_RPT];
                  hw_q   <= cfg_wdata[CB_HW];
                  dir_q  <= cfg_wdata[CB_DIR];
                  sel_q  <= cfg_wdata[CB_SEL +: SEL_W];
                  if (cfg_wdata[CB_EN] && !en_q)
                     fwd_q <= cfg_wdata[CB_DIR] ? dst_q : src_q;
               end
               default: ;
            endcase
         end
         en_q   <= en_nxt;
         pend_q <= pend_nxt;
         done_q <= last;
      end
   end

   always_comb begin
      ctrl_v                   = '0;
      ctrl_v[CB_EN]            = en_q;
      ctrl_v[CB_WORD]          = word_q;
      ctrl_v[CB_RPT]           = rpt_q;
      ctrl_v[CB_HW]            = hw_q;
      ctrl_v[CB_DIR]           = dir_q;
      ctrl_v[CB_SEL +: SEL_W]  = sel_q;
      case (cfg_reg)
         RG_SRC:    rd_data = src_q;
         RG_DST:    rd_data = dst_q;
         RG_COUNT:  rd_data = ADDR_W'(cnt_q);
         RG_CTRL:   rd_data = ctrl_v;
         RG_FWD:    rd_data = fwd_q;
         RG_RELOAD: rd_data = ADDR_W'(rld_q);
         default:   rd_data = '0;
      endcase
   end

   assign pend    = pend_q;
   assign done    = done_q;
   assign word    = word_q;
   assign rd_addr = dir_q ? src_q : fwd_q;
   assign wr_addr = dir_q ? fwd_q : dst_q;

endmodule

// File: rtl/cs_dma_pick.sv
module cs_dma_pick #(
   parameter bit LOW_FIRST = 1'b1
) (
   input  logic [1:0] pend,
   output logic [1:0] pick
);

   generate
      if (LOW_FIRST) begin : g_low
         always_comb begin
            if (pend[0])      pick = 2'b01;
            else if (pend[1]) pick = 2'b10;
            else              pick = 2'b00;
         end
      end else begin : g_high
         always_comb begin
            if (pend[1])      pick = 2'b10;
            else if (pend[0]) pick = 2'b01;
            else              pick = 2'b00;
         end
      end
   endgenerate

endmodule

// File: rtl/cs_dma_mover.sv
module cs_dma_mover
   import cs_dma_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        want,
   input  logic              bus_gnt,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic              word,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic [1:0]        take,
   output logic [1:0]        fin,
   output logic              cur,
   output logic              bus_req,
   output logic              bus_rd,
   output logic              bus_wr,
   output logic              bus_word,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata
);

   mv_state_t         st_q;
   logic              cur_q;
   logic [DATA_W-1:0] latch_q;

   assign take = (st_q == MV_IDLE && bus_gnt) ? want : 2'b00;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= MV_IDLE;
         cur_q   <= 1'b0;
         latch_q <= '0;
      end else begin
         case (st_q)
            MV_IDLE: if (|take) begin
               cur_q <= take[1];
               st_q  <= MV_READ;
            end
            MV_READ: begin
               latch_q <= word ? bus_rdata
                               : {{(DATA_W-8){1'b0}}, bus_rdata[7:0]};
               st_q    <= MV_WRITE;
            end
            MV_WRITE: st_q <= MV_REST;
            default:  st_q <= MV_IDLE;
         endcase
      end
   end

   always_comb begin
      bus_rd    = (st_q == MV_READ);
      bus_wr    = (st_q == MV_WRITE);
      bus_req   = bus_rd || bus_wr || (st_q == MV_IDLE && |want);
      bus_word  = (bus_rd || bus_wr) && word;
      bus_addr  = bus_rd ? rd_addr : (bus_wr ? wr_addr : '0);
      bus_wdata = bus_wr ? latch_q : '0;
      fin       = bus_wr ? (cur_q ? 2'b10 : 2'b01) : 2'b00;
   end

   assign cur = cur_q;

endmodule

// File: rtl/cs_dma2.sv
module cs_dma2
   import cs_dma_pkg::*;
#(
   parameter int ADDR_W    = 20,
   parameter int CNT_W     = 16,
   parameter int DATA_W    = 16,
   parameter int IRQ_N     = 8,
   parameter bit LOW_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [3:0]        cfg_addr,
   input  logic [ADDR_W-1:0] cfg_wdata,
   output logic [ADDR_W-1:0] cfg_rdata,
   input  logic [IRQ_N-1:0]  irq,
   output logic              bus_req,
   input  logic              bus_gnt,
   output logic              bus_rd,
   output logic              bus_wr,
   output logic              bus_word,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic [1:0]        done
);

   localparam int CH_N  = 2;
   localparam int SEL_W = $clog2(IRQ_N);

   generate
      if (DATA_W != 16) begin : g_bad_data
         $error("cs_dma2: DATA_W must be 16");
      end
      if (CNT_W > ADDR_W || CB_SEL + SEL_W > ADDR_W) begin : g_bad_cfg
         $error("cs_dma2: register fields do not fit ADDR_W");
      end
      if (IRQ_N < 2 || IRQ_N != (1 << SEL_W)) begin : g_bad_irq
         $error("cs_dma2: IRQ_N must be a power of two");
      end
   endgenerate

   logic [IRQ_N-1:0]  irq_q, irq_rise;
   logic [CH_N-1:0]   ch_pend, ch_take, ch_fin, ch_word, ch_pick;
   logic [ADDR_W-1:0] ch_rd_addr [CH_N];
   logic [ADDR_W-1:0] ch_wr_addr [CH_N];
   logic [ADDR_W-1:0] ch_rdata   [CH_N];
   logic              cur;

   always_ff @(posedge clk) begin
      if (!rst_n) irq_q <= '0;
      else        irq_q <= irq;
   end
   assign irq_rise = irq & ~irq_q;

   generate
      for (genvar c = 0; c < CH_N; c++) begin : g_ch
         cs_dma_chan #(
            .ADDR_W (ADDR_W),
            .CNT_W  (CNT_W),
            .IRQ_N  (IRQ_N)
         ) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg_we    (cfg_we && (cfg_addr[3] == 1'(c))),
            .cfg_reg   (cfg_addr[2:0]),
            .cfg_wdata (cfg_wdata),
            .irq_rise  (irq_rise),
            .take      (ch_take[c]),
            .fin       (ch_fin[c]),
            .pend      (ch_pend[c]),
            .rd_addr   (ch_rd_addr[c]),
            .wr_addr   (ch_wr_addr[c]),
            .word      (ch_word[c]),
            .rd_data   (ch_rdata[c]),
            .done      (done[c])
         );
      end
   endgenerate

   cs_dma_pick #(.LOW_FIRST(LOW_FIRST)) u_pick (
      .pend (ch_pend),
      .pick (ch_pick)
   );

   cs_dma_mover #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mover (
      .clk       (clk),
      .rst_n     (rst_n),
      .want      (ch_pick),
      .bus_gnt   (bus_gnt),
      .rd_addr   (ch_rd_addr[cur]),
      .wr_addr   (ch_wr_addr[cur]),
      .word      (ch_word[cur]),
      .bus_rdata (bus_rdata),
      .take      (ch_take),
      .fin       (ch_fin),
      .cur       (cur),
      .bus_req   (bus_req),
      .bus_rd    (bus_rd),
      .bus_wr    (bus_wr),
      .bus_word  (bus_word),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata)
   );

   assign cfg_rdata = ch_rdata[cfg_addr[3]];

endmodule

// File: rtl/cs_dma_chk.sv
module cs_dma_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       bus_req,
   input logic       bus_gnt,
   input logic       bus_rd,
   input logic       bus_wr,
   input logic       bus_word,
   input logic [7:0] wdata_hi,
   input logic [1:0] done,
   input logic [1:0] pend,
   input logic [1:0] take
);

   a_r3_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd |=> bus_wr);

   a_r12_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd |-> !bus_wr);

   a_r11_only_granted: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd || bus_wr) |-> bus_gnt);

   a_r11_bus_returned: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr |=> !bus_req);

   a_r4_byte_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !bus_word) |-> (wdata_hi == 8'h00));

   a_r6_done0_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      done[0] |=> !done[0]);

   a_r6_done1_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      done[1] |=> !done[1]);

   a_r1_ch0_first: assert property (@(posedge clk) disable iff (!rst_n)
      take[1] |-> !pend[0]);

   a_r10_one_take: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(take));

   a_r8_take_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
      (take[0] |-> pend[0]) and (take[1] |-> pend[1]));

endmodule

bind cs_dma2 cs_dma_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_req  (bus_req),
   .bus_gnt  (bus_gnt),
   .bus_rd   (bus_rd),
   .bus_wr   (bus_wr),
   .bus_word (bus_word),
   .wdata_hi (bus_wdata[15:8]),
   .done     (done),
   .pend     (ch_pend),
   .take     (ch_take)
);

// File: tb/cs_dma2_test.sv
module cs_dma2_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [3:0]  cfg_addr = '0;
   logic [19:0] cfg_wdata = '0;
   logic [19:0] cfg_rdata;
   logic [7:0]  irq = '0;
   logic        bus_req, bus_gnt, bus_rd, bus_wr, bus_word;
   logic [19:0] bus_addr;
   logic [15:0] bus_wdata, bus_rdata;
   logic [1:0]  done;
   logic        cpu_hold = 1'b0;

   int n_cmp = 0;
   int n_bad = 0;
   int done0 = 0;
   int done1 = 0;
   int req_seen = 0;
   logic prev_wr = 1'b0;

   typedef struct packed {
      logic [19:0] ra;
      logic [19:0] wa;
      logic [15:0] data;
      logic        word;
   } item_t;
   item_t sb[$];

   logic [7:0] mem [256];

   always #4 clk = ~clk;

   cs_dma2 uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq(irq),
      .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_word(bus_word), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .done(done)
   );

   assign bus_gnt   = bus_req && !cpu_hold;
   assign bus_rdata = {mem[8'(bus_addr[7:0] + 8'd1)], mem[bus_addr[7:0]]};

   function automatic logic [7:0] pat(input logic [7:0] a);
      return 8'(a * 8'd7 + 8'd3);
   endfunction

   function automatic logic [15:0] pat16(input logic [7:0] a);
      return {pat(8'(a + 8'd1)), pat(a)};
   endfunction

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = pat(8'(i));
   end

   always @(posedge clk) begin
      if (bus_wr && bus_gnt) begin
         mem[bus_addr[7:0]] <= bus_wdata[7:0];
         if (bus_word) mem[8'(bus_addr[7:0] + 8'd1)] <= bus_wdata[15:8];
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // monitor: scoreboard pop on every bus cycle, bus release check
   always @(negedge clk) begin
      if (rst_n) begin
         if (done[0]) done0++;
         if (done[1]) done1++;
         if (bus_req) req_seen++;
         if (prev_wr) check("R11 bus_req after write", 32'(bus_req), 32'd0);
         if (bus_rd) begin
            if (sb.size() == 0) check("R3 unexpected read", 32'd1, 32'd0);
            else check("R3 read address", 32'(bus_addr), 32'(sb[0].ra));
         end
         if (bus_wr) begin
            if (sb.size() == 0) check("R3 unexpected write", 32'd1, 32'd0);
            else begin
               item_t it;
               it = sb.pop_front();
               check("R3 write address", 32'(bus_addr), 32'(it.wa));
               check("R3/R4 write data", 32'(bus_wdata), 32'(it.data));
               check("R4 size", 32'(bus_word), 32'(it.word));
            end
         end
         prev_wr = bus_wr;
      end
   end

   task automatic wr(input logic [3:0] a, input logic [19:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic rd_check(input string tag, input logic [3:0] a, input logic [19:0] exp);
      @(negedge clk);
      cfg_addr = a;
      #1;
      check(tag, 32'(cfg_rdata), 32'(exp));
   endtask

   task automatic expect_xfer(input logic [19:0] ra, input logic [19:0] wa,
                              input logic [15:0] d, input logic w);
      item_t it;
      it.ra = ra; it.wa = wa; it.data = d; it.word = w;
      sb.push_back(it);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // R2 reset state
      check("R2 bus_req", 32'(bus_req), 32'd0);
      check("R2 done", 32'(done), 32'd0);
      rd_check("R2 ch0 ctrl", 4'h3, 20'h0);
      rd_check("R2 ch1 count", 4'hA, 20'h0);

      // channel 0: word, source advances, single mode, 3 transfers
      wr(4'h0, 20'h10);
      wr(4'h1, 20'h80);
      wr(4'h2, 20'd3);
      wr(4'h3, 20'h03);
      rd_check("R5 fwd loaded from source", 4'h5, 20'h10);
      for (int k = 0; k < 3; k++) begin
         expect_xfer(20'(8'h10 + 8'(2 * k)), 20'h80, pat16(8'(8'h10 + 8'(2 * k))), 1'b1);
         wr(4'h4, 20'h1);
         idle(10);
         if (k == 0) rd_check("R6 count decremented", 4'h2, 20'd2);
      end
      check("R3 ch0 transfers drained", 32'(sb.size()), 32'd0);
      rd_check("R5 fwd advanced by 2", 4'h5, 20'h16);
      rd_check("R6 enable cleared", 4'h3, 20'h02);
      check("R6 done0 pulses", 32'(done0), 32'd1);

      // R8 strobe to a disabled channel
      req_seen = 0;
      wr(4'h4, 20'h1);
      idle(12);
      check("R8 disabled strobe ignored", 32'(req_seen), 32'd0);

      // channel 1: byte, destination advances, repeat, irq line 3
      wr(4'h8, 20'h20);
      wr(4'h9, 20'h90);
      wr(4'hA, 20'd2);
      wr(4'hB, 20'd125);
      rd_check("R5 fwd loaded from destination", 4'hD, 20'h90);
      expect_xfer(20'h20, 20'h90, {8'h00, pat(8'h20)}, 1'b0);
      @(negedge clk); irq[3] = 1'b1;
      idle(14);
      check("R9 held level one transfer", 32'(sb.size()), 32'd0);
      req_seen = 0;
      @(negedge clk); irq[2] = 1'b1;
      idle(10);
      check("R9 unselected line ignored", 32'(req_seen), 32'd0);
      @(negedge clk); irq = '0;
      idle(2);
      expect_xfer(20'h20, 20'h91, {8'h00, pat(8'h20)}, 1'b0);
      @(negedge clk); irq[3] = 1'b1;
      idle(12);
      @(negedge clk); irq = '0;
      check("R4 byte transfers drained", 32'(sb.size()), 32'd0);
      rd_check("R7 count reloaded", 4'hA, 20'd2);
      rd_check("R7 reload value", 4'hE, 20'd2);
      rd_check("R7 fwd rewound", 4'hD, 20'h90);
      rd_check("R7 still enabled", 4'hB, 20'd125);
      check("R7 done1 pulses", 32'(done1), 32'd1);
      check("R1 ch0 unaffected by ch1", 32'(done0), 32'd1);

      // priority and merging with the bus held by the CPU
      wr(4'h0, 20'h30);
      wr(4'h1, 20'hA0);
      wr(4'h2, 20'd4);
      wr(4'h3, 20'h13);
      rd_check("R5 fwd from destination ch0", 4'h5, 20'hA0);
      @(negedge clk); cpu_hold = 1'b1;
      wr(4'hC, 20'h1);
      wr(4'h4, 20'h1);
      wr(4'h4, 20'h1);
      idle(4);
      expect_xfer(20'h30, 20'hA0, pat16(8'h30), 1'b1);
      expect_xfer(20'h20, 20'h90, {8'h00, pat(8'h20)}, 1'b0);
      @(negedge clk); cpu_hold = 1'b0;
      idle(16);
      check("R1 both served", 32'(sb.size()), 32'd0);
      rd_check("R10 merged into one transfer", 4'h2, 20'd3);
      rd_check("R5 fwd advanced at destination", 4'h5, 20'hA2);
      rd_check("R10 ch1 one transfer", 4'hA, 20'd1);
      finish_run();
   end

endmodule